// File: doc/BRIEF.md
# Sigma-Delta Oscillator Control Word Encoder

This block converts an 11-bit oscillator frequency control word into the drive codes of a unary tuning DAC with 262 unit elements. The upper eight bits select how many of 255 integer elements are switched on, as a thermometer code that is refreshed on each loop-clock enable. The three low bits are captured at the same moment. On each oversampling-clock enable, a third-order cascade of three noise-shaping accumulators processes those bits. Its combined, offset output switches between zero and seven of a further seven fractional elements. Averaged over time, the fractional elements therefore add a fine step of one eighth of a unit element.

The oversampling enable is expected to pulse sixteen times for each loop enable. A separate modulator enable freezes the fine path. While it is low, each oversampling enable clears the modulator state and parks the fractional code at its midpoint of three elements. Only whole integer steps then reach the oscillator.

Top module: `dco_word_encoder`

## Requirements
- R1: After reset, `intTherm` is all zero and `fracTherm` is 7'b0000111. The modulator accumulators start at zero, so the first modulator step after reset with a held fraction of 7 yields 7'b0000111.
- R2: On a clock edge with `loopEn` high, `intTherm` takes the thermometer code of `ctrlWord[10:3]`: bits below that value are 1 and all others 0.
- R3: `ctrlWord[2:0]` is captured only on a `loopEn` edge. A modulator step on the same edge still uses the fraction held before that edge.
- R4: A modulator step is an edge with `osEn` and `modEn` both high. After each step, `fracTherm` is a thermometer code whose number of ones equals the modulator output plus 3, with the output in the range -3 to +4.
- R5: Starting from cleared state, 128 consecutive steps with held fraction f switch on 384 + 16·f fractional elements in total, to within 2.
- R6: With held fraction 0, every step leaves `fracTherm` at 7'b0000111.
- R7: An edge with `osEn` high and `modEn` low clears all modulator state and sets `fracTherm` to 7'b0000111. The code stays there while `modEn` stays low.
- R8: `intTherm` changes only on `loopEn` edges, and `fracTherm` changes only on `osEn` edges.
- R9: From cleared state with held fraction 4, the first two steps give 7'b0000111 and then 7'b0011111. This fixes the combiner as c1 + (c2 − c2 delayed) + (c3 − 2·c3 delayed + c3 delayed twice).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWord | input | 11 | Control word: integer part in [10:3], fraction in [2:0] |
| loopEn | input | 1 | Loop-rate enable: updates integer code and captures fraction |
| osEn | input | 1 | Oversampling enable for the modulator |
| modEn | input | 1 | Modulator enable; low parks the fractional code at midpoint |
| intTherm | output | 255 | Integer thermometer code |
| fracTherm | output | 7 | Fractional thermometer code |

## Verification
A loop enable and an oversampling enable can land on the same edge. The integer code must then update while the modulator step consumes the fraction captured before that edge. The bench primes the modulator with fraction 4 and takes one step. It then applies a new word with fraction 0 and raises both enables in one cycle. It checks the new integer count, the code of five elements that only the old fraction produces, and the code of one element on the following step, which is the step that uses the new fraction.

// File: rtl/dco_enc_pkg.sv
package dco_enc_pkg;

  typedef struct packed {
    logic intLoad;
    logic modStep;
    logic modClear;
  } encStrobe_t;

endpackage

// File: rtl/therm_encode.sv
module therm_encode #(
  parameter int WIDTH    = 7,
  parameter int CNT_BITS = 3
) (
  input  logic [CNT_BITS-1:0] count,
  output logic [WIDTH-1:0]    therm
);

  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    localparam logic [CNT_BITS-1:0] IDX = CNT_BITS'(i);
    assign therm[i] = (count > IDX);
  end

endmodule

// File: rtl/mash_accum.sv
module mash_accum #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         step,
  input  logic         clear,
  input  logic [W-1:0] addend,
  output logic [W-1:0] residue,
  output logic         carry
);

  logic [W-1:0] acc;
  logic [W:0]   sum;

  assign sum     = {1'b0, acc} + {1'b0, addend};
  assign residue = sum[W-1:0];
  assign carry   = sum[W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      acc <= '0;
    else if (clear) acc <= '0;
    else if (step)  acc <= residue;
  end

  // R7: a clear leaves the accumulator empty
  p_acc_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (acc == '0));

  // R8: no step and no clear means no change
  p_acc_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(step || clear) |=> $stable(acc));

endmodule

// File: rtl/dco_enc_ctrl.sv
module dco_enc_ctrl
  import dco_enc_pkg::*;
(
  input  logic       loopEn,
  input  logic       osEn,
  input  logic       modEn,
  output encStrobe_t strobe
);

  assign strobe.intLoad  = loopEn;
  assign strobe.modStep  = osEn & modEn;
  assign strobe.modClear = osEn & ~modEn;

endmodule

// File: rtl/dco_enc_dp.sv
module dco_enc_dp
  import dco_enc_pkg::*;
#(
  parameter int INT_BITS  = 8,
  parameter int FRAC_BITS = 3,
  parameter int INT_ELEMS = 255,
  parameter int FRAC_ELEMS = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  encStrobe_t            strobe,
  input  logic [INT_BITS-1:0]   intPart,
  input  logic [FRAC_BITS-1:0]  fracPart,
  output logic [INT_ELEMS-1:0]  intTherm,
  output logic [FRAC_ELEMS-1:0] fracTherm
);

  localparam int MASH_ORDER = 3;
  localparam int CODE_BITS  = MASH_ORDER;
  localparam int FRAC_MID   = (1 << (MASH_ORDER - 1)) - 1;
  localparam logic [FRAC_ELEMS-1:0] FRAC_IDLE = FRAC_ELEMS'((1 << FRAC_MID) - 1);

  // integer path
  logic [INT_ELEMS-1:0] intNext;
  logic [FRAC_BITS-1:0] fracHold;

  therm_encode #(.WIDTH(INT_ELEMS), .CNT_BITS(INT_BITS)) uIntEnc (
    .count (intPart),
    .therm (intNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intTherm <= '0;
      fracHold <= '0;
    end else if (strobe.intLoad) begin
      intTherm <= intNext;
      fracHold <= fracPart;
    end
  end

  // cascaded accumulators
  logic [FRAC_BITS-1:0]  stageIn  [MASH_ORDER];
  logic [FRAC_BITS-1:0]  stageRes [MASH_ORDER];
  logic [MASH_ORDER-1:0] carry;

  for (genvar k = 0; k < MASH_ORDER; k++) begin : gStage
    if (k == 0) begin : gHead
      assign stageIn[k] = fracHold;
    end else begin : gTail
      assign stageIn[k] = stageRes[k-1];
    end
    mash_accum #(.W(FRAC_BITS)) uAcc (
      .clk     (clk),
      .rstN    (rstN),
      .step    (strobe.modStep),
      .clear   (strobe.modClear),
      .addend  (stageIn[k]),
      .residue (stageRes[k]),
      .carry   (carry[k])
    );
  end

  // combiner delay line and output code
  logic c2Dly, c3Dly, c3Dly2;
  logic signed [3:0] yVal;
  logic signed [3:0] codeVal;
  logic [CODE_BITS-1:0] fracCode;
  logic [FRAC_ELEMS-1:0] fracNext;

  always_comb begin
    yVal = $signed({3'b000, carry[0]})
         + $signed({3'b000, carry[1]}) - $signed({3'b000, c2Dly})
         + $signed({3'b000, carry[2]}) - $signed({2'b00, c3Dly, 1'b0})
         + $signed({3'b000, c3Dly2});
    codeVal  = yVal + 4'sd3;
    fracCode = codeVal[CODE_BITS-1:0];
  end

  therm_encode #(.WIDTH(FRAC_ELEMS), .CNT_BITS(CODE_BITS)) uFracEnc (
    .count (fracCode),
    .therm (fracNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      c2Dly     <= 1'b0;
      c3Dly     <= 1'b0;
      c3Dly2    <= 1'b0;
      fracTherm <= FRAC_IDLE;
    end else if (strobe.modClear) begin
      c2Dly     <= 1'b0;
      c3Dly     <= 1'b0;
      c3Dly2    <= 1'b0;
      fracTherm <= FRAC_IDLE;
    end else if (strobe.modStep) begin
      c2Dly     <= carry[1];
      c3Dly     <= carry[2];
      c3Dly2    <= c3Dly;
      fracTherm <= fracNext;
    end
  end

  // R2: integer count follows the captured word
  p_int_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.intLoad |=> ($countones(intTherm) == int'($past(intPart))));

  // R8: integer code holds between loop enables
  p_int_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.intLoad |=> $stable(intTherm));

  // R8: fractional code holds without an oversampling enable
  p_frac_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.modStep || strobe.modClear) |=> $stable(fracTherm));

  // R7: disabled modulator parks at midpoint
  p_park_mid_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.modClear |=> (fracTherm == FRAC_IDLE));

  // R4: each step leaves a well-formed thermometer code
  p_frac_shape_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.modStep |=> ((fracTherm & (fracTherm + 1'b1)) == '0));

  // R7: after a clear every stage passes the held fraction straight through
  p_clear_chain_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.modClear |=> (stageRes[MASH_ORDER-1] == fracHold));

endmodule

// File: rtl/dco_word_encoder.sv
module dco_word_encoder
  import dco_enc_pkg::*;
#(
  parameter int INT_BITS  = 8,
  parameter int FRAC_BITS = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [INT_BITS+FRAC_BITS-1:0]      ctrlWord,
  input  logic                               loopEn,
  input  logic                               osEn,
  input  logic                               modEn,
  output logic [(1 << INT_BITS)-2:0]         intTherm,
  output logic [6:0]                         fracTherm
);

  localparam int WORD_BITS  = INT_BITS + FRAC_BITS;
  localparam int INT_ELEMS  = (1 << INT_BITS) - 1;
  localparam int FRAC_ELEMS = 7;

  encStrobe_t strobe;

  dco_enc_ctrl uCtrl (
    .loopEn (loopEn),
    .osEn   (osEn),
    .modEn  (modEn),
    .strobe (strobe)
  );

  dco_enc_dp #(
    .INT_BITS   (INT_BITS),
    .FRAC_BITS  (FRAC_BITS),
    .INT_ELEMS  (INT_ELEMS),
    .FRAC_ELEMS (FRAC_ELEMS)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .intPart   (ctrlWord[WORD_BITS-1:FRAC_BITS]),
    .fracPart  (ctrlWord[FRAC_BITS-1:0]),
    .intTherm  (intTherm),
    .fracTherm (fracTherm)
  );

endmodule

// File: tb/dco_word_encoder_test.sv
module dco_word_encoder_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [10:0]  ctrlWord = '0;
  logic         loopEn = 1'b0;
  logic         osEn = 1'b0;
  logic         modEn = 1'b0;
  logic [254:0] intTherm;
  logic [6:0]   fracTherm;

  int testsRun = 0;
  int testsFailed = 0;

  dco_word_encoder uut (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWord  (ctrlWord),
    .loopEn    (loopEn),
    .osEn      (osEn),
    .modEn     (modEn),
    .intTherm  (intTherm),
    .fracTherm (fracTherm)
  );

  always #10 clk = ~clk;

  localparam int NVEC = 8;
  localparam logic [10:0] VEC_WORD [NVEC] =
    '{11'h000, 11'h7FF, 11'h008, 11'h007, 11'h3F5, 11'h400, 11'h7F8, 11'h2AB};
  localparam int VEC_CNT [NVEC] = '{0, 255, 1, 0, 126, 128, 255, 85};

  function automatic logic [254:0] thermOf(input int n);
    logic [254:0] v;
    for (int i = 0; i < 255; i++) v[i] = (i < n);
    return v;
  endfunction

  task automatic check(input string req, input logic [254:0] act, input logic [254:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkNear(input string req, input int act, input int exp, input int tol);
    testsRun++;
    if (act > exp + tol || act < exp - tol) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d+-%0d", req, act, exp, tol);
    end
  endtask

  // inputs change at negedge; one posedge; sample at following negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic loadWord(input logic [10:0] w);
    ctrlWord = w;
    loopEn = 1'b1;
    tick();
    loopEn = 1'b0;
  endtask

  task automatic clearMod();
    modEn = 1'b0;
    osEn = 1'b1;
    tick();
    osEn = 1'b0;
  endtask

  task automatic stepMod();
    modEn = 1'b1;
    osEn = 1'b1;
    tick();
    osEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [254:0] heldInt;
    logic [6:0] heldFrac;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 reset intTherm", intTherm, '0);
    check("R1 reset fracTherm", {248'b0, fracTherm}, 255'h07);
    rstN = 1'b1;
    tick();

    // R1 accumulators start empty: fraction 7 first step gives no carry
    loadWord(11'h007);
    stepMod();
    check("R1 first step from reset", {248'b0, fracTherm}, 255'h07);

    // R2 table walk, R8 fractional code untouched by loop enables
    heldFrac = fracTherm;
    for (int v = 0; v < NVEC; v++) begin
      loadWord(VEC_WORD[v]);
      check($sformatf("R2 vector %0d", v), intTherm, thermOf(VEC_CNT[v]));
    end
    check("R8 frac hold across loop enables", {248'b0, fracTherm}, {248'b0, heldFrac});

    // R8 integer code holds when word changes without loopEn
    heldInt = intTherm;
    ctrlWord = 11'h123;
    osEn = 1'b1; modEn = 1'b1;
    tick(); tick();
    osEn = 1'b0;
    check("R8 int hold without loopEn", intTherm, heldInt);

    // R5 and R4: averages over 128 steps
    for (int f = 1; f < 8; f += 2) begin
      int total;
      int badShape;
      total = 0;
      badShape = 0;
      loadWord({8'h40, 3'(f)});
      clearMod();
      modEn = 1'b1;
      osEn = 1'b1;
      for (int s = 0; s < 128; s++) begin
        tick();
        total += $countones(fracTherm);
        if ((fracTherm & (fracTherm + 7'd1)) != 7'd0) badShape++;
      end
      osEn = 1'b0;
      check($sformatf("R4 shape f=%0d", f), 255'(badShape), '0);
      checkNear($sformatf("R5 average f=%0d", f), total, 384 + 16 * f, 2);
    end

    // R6 zero fraction stays at midpoint
    begin
      int offMid;
      offMid = 0;
      loadWord(11'h050);
      clearMod();
      for (int s = 0; s < 16; s++) begin
        stepMod();
        if (fracTherm != 7'h07) offMid++;
      end
      check("R6 zero fraction mismatches", 255'(offMid), '0);
    end

    // R7 disable parks and clears
    loadWord(11'h035);
    repeat (5) stepMod();
    heldInt = intTherm;
    clearMod();
    check("R7 park on disable", {248'b0, fracTherm}, 255'h07);
    osEn = 1'b1; modEn = 1'b0;
    repeat (5) tick();
    osEn = 1'b0;
    check("R7 stays parked", {248'b0, fracTherm}, 255'h07);
    check("R7 int untouched", intTherm, heldInt);

    // R9 combiner sequence with fraction 4 from cleared state
    loadWord(11'h004);
    stepMod();
    check("R9 step1 frac4", {248'b0, fracTherm}, 255'h07);
    stepMod();
    check("R9 step2 frac4", {248'b0, fracTherm}, 255'h1F);

    // R3 coincident loop and oversampling enables
    clearMod();
    stepMod();
    ctrlWord = {8'h9A, 3'd0};
    loopEn = 1'b1; osEn = 1'b1; modEn = 1'b1;
    tick();
    loopEn = 1'b0; osEn = 1'b0;
    check("R3 int on coincident edge", intTherm, thermOf(8'h9A));
    check("R3 step uses old fraction", {248'b0, fracTherm}, 255'h1F);
    stepMod();
    check("R3 next step uses new fraction", {248'b0, fracTherm}, 255'h01);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule